// File: doc/BRIEF.md
# Narrowing Vector Right-Shift Engine

This engine runs a narrowing right shift across a group of vector elements, one element per clock. Each source element is twice the selected element width (SEW) and comes from a register group. The shift amount comes either from an SEW-wide element of a second group or from a scalar operand. The engine shifts the wide value logically or arithmetically, keeps the low SEW bits and writes them to the destination group. The register file lives inside the block. It is built from NREG registers of VLEN bits, with register 0 serving as the mask source.

A command enters over a valid/ready handshake. `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_valid` has no effect while `cmd_ready` is low. While a command runs, the engine walks the element index from the start index up to the length minus one. It skips masked-off elements and reports completion with a one-cycle `done` pulse. A host port loads and reads whole registers. Host loads are refused while the engine is busy.

Top module: `nsu_top`

## Requirements
- R1: After reset, `cmd_ready`=1, `busy`=0, `done`=0, `dirty`=0, `vstart_o`=0, and every register reads zero.
- R2: `cmd_sew` 0, 1 and 2 select SEW 8, 16 and 32. Element i of a group that starts at register b sits little-endian at byte b*VLEN/8 + i*W, where W is SEW/8 for narrow elements and 2*SEW/8 for wide sources. Any other destination byte is left unchanged.
- R3: With `cmd_scalar_sel`=0, the shift amount is element i of group `cmd_vs1`, read at SEW width and then masked with 2*SEW-1.
- R4: With `cmd_scalar_sel`=1, the shift amount is `cmd_scalar` masked with 2*SEW-1.
- R5: With `cmd_arith`=1, the 2*SEW source is treated as signed and the vacated bits fill with its sign bit.
- R6: With `cmd_arith`=0, the vacated bits fill with zeros.
- R7: Only the low SEW bits of the shifted value are written.
- R8: With `cmd_unmasked`=0, element i is processed only when bit i of register 0 is set. Bit i is bit i%8 of byte i/8. The mask is captured when the command is accepted, so writes into register 0 during the run do not change which elements are processed.
- R9: Only elements with index from `cmd_vstart` to `cmd_vl`-1 are written.
- R10: For a command with n = vl-vstart > 0, `done` rises n+1 edges after the accepting edge, counting the accepting edge as the first. `done` lasts one cycle. While `done` is high, `vstart_o` is 0 and `dirty` is 1. `dirty` stays set until reset.
- R11: If `cmd_vstart` >= `cmd_vl`, nothing is written and `done` is high right after the accepting edge.
- R12: While `busy` is high, `cmd_ready` is 0 and host register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_sew | input | 2 | Narrow element width code |
| cmd_arith | input | 1 | 1 = arithmetic shift, 0 = logical |
| cmd_scalar_sel | input | 1 | 1 = shift amount from cmd_scalar |
| cmd_scalar | input | XLEN | Scalar shift amount |
| cmd_unmasked | input | 1 | 1 = all elements active |
| cmd_vstart | input | IW | First element index |
| cmd_vl | input | IW | Element count limit |
| cmd_vd | input | RW | Destination group base register |
| cmd_vs2 | input | RW | Wide source group base register |
| cmd_vs1 | input | RW | Shift amount group base register |
| host_we | input | 1 | Host register write strobe |
| host_reg | input | RW | Host register select |
| host_wdata | input | VLEN | Host write data |
| host_rdata | output | VLEN | Contents of the selected register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| vstart_o | output | IW | Current element index, cleared on completion |
| dirty | output | 1 | Sticky flag set when a command completes |

## Verification
On every cycle, the assertions check the following: the single-cycle `done` pulse, the cleared index and set `dirty` at completion, the early finish of an empty command, and that the index never reaches the length while the engine runs. They also check that the register file is never written by the engine while it is idle. The other requirements concern data values and can only be shown by the bench scenarios. These include the shift arithmetic at each width, the masking of the shift amount, the sign fill, the truncation, the mask snapshot when the destination overlaps register 0, and the bytes left untouched outside the active index range. The bench compares every register against its own byte-level model after each command.

// File: rtl/nsu_pkg.sv
package nsu_pkg;
  // narrow element width in bytes for a width code (3 treated as 32-bit)
  function automatic logic [3:0] sew_nbytes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } nsu_state_e;
endpackage

// File: rtl/nsu_regfile.sv
module nsu_regfile #(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  localparam int VLENB = VLEN / 8,
  localparam int NBYTE = NREG * VLENB,
  localparam int AW = $clog2(NBYTE),
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic            host_block,
  input  logic [RW-1:0]   host_reg,
  input  logic [VLEN-1:0] host_wdata,
  output logic [VLEN-1:0] host_rdata,
  output logic [VLEN-1:0] v0_bits,
  input  logic [AW-1:0]   wide_addr,
  output logic [63:0]     wide_data,
  input  logic [AW-1:0]   amt_addr,
  output logic [7:0]      amt_byte,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [3:0]      wr_nb,
  input  logic [31:0]     wr_data
);
  logic [7:0] mem [NBYTE];

  always_comb begin
    for (int k = 0; k < 8; k++)
      wide_data[8*k +: 8] = mem[AW'(int'(wide_addr) + k)];
    amt_byte = mem[amt_addr];
    for (int b = 0; b < VLENB; b++) begin
      host_rdata[8*b +: 8] = mem[AW'(int'(host_reg) * VLENB + b)];
      v0_bits[8*b +: 8]    = mem[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) mem[i] <= '0;
    end else begin
      if (host_we && !host_block)
        for (int b = 0; b < VLENB; b++)
          mem[AW'(int'(host_reg) * VLENB + b)] <= host_wdata[8*b +: 8];
      if (wr_en)
        for (int k = 0; k < 4; k++)
          if (k < int'(wr_nb)) mem[AW'(int'(wr_addr) + k)] <= wr_data[8*k +: 8];
    end
  end
endmodule

// File: rtl/nsu_alu.sv
module nsu_alu #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      sew,
  input  logic            arith,
  input  logic [63:0]     wide,
  input  logic [XLEN-1:0] shamt_raw,
  output logic [31:0]     result
);
  logic [6:0]  wbits;
  logic [5:0]  amt;
  logic [63:0] ext;
  logic [63:0] shifted;

  always_comb begin
    case (sew)
      2'd0:    wbits = 7'd16;
      2'd1:    wbits = 7'd32;
      default: wbits = 7'd64;
    endcase
    // shift amount reduced modulo the wide width
    amt = 6'(shamt_raw & XLEN'(wbits - 7'd1));
    case (sew)
      2'd0:    ext = {{48{arith & wide[15]}}, wide[15:0]};
      2'd1:    ext = {{32{arith & wide[31]}}, wide[31:0]};
      default: ext = wide;
    endcase
    shifted = arith ? 64'($signed(ext) >>> amt) : (ext >> amt);
    case (sew)
      2'd0:    result = {24'd0, shifted[7:0]};
      2'd1:    result = {16'd0, shifted[15:0]};
      default: result = shifted[31:0];
    endcase
  end
endmodule

// File: rtl/nsu_seq.sv
module nsu_seq
  import nsu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int XLEN = 32,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_sew,
  input  logic            cmd_arith,
  input  logic            cmd_scalar_sel,
  input  logic [XLEN-1:0] cmd_scalar,
  input  logic            cmd_unmasked,
  input  logic [IW-1:0]   cmd_vstart,
  input  logic [IW-1:0]   cmd_vl,
  input  logic [RW-1:0]   cmd_vd,
  input  logic [RW-1:0]   cmd_vs2,
  input  logic [RW-1:0]   cmd_vs1,
  input  logic [VLEN-1:0] v0_bits,
  output logic [1:0]      q_sew,
  output logic            q_arith,
  output logic            q_scalar_sel,
  output logic [XLEN-1:0] q_scalar,
  output logic [RW-1:0]   q_vd,
  output logic [RW-1:0]   q_vs2,
  output logic [RW-1:0]   q_vs1,
  output logic [IW-1:0]   idx,
  output logic            elem_we,
  output logic            busy,
  output logic            done,
  output logic            dirty
);
  nsu_state_e      st;
  logic [IW-1:0]   vl_q;
  logic [VLEN-1:0] mask_q;

  assign cmd_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_FIN);
  assign elem_we   = (st == ST_RUN) && mask_q[idx[IW-2:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      idx          <= '0;
      dirty        <= 1'b0;
      vl_q         <= '0;
      mask_q       <= '0;
      q_sew        <= '0;
      q_arith      <= 1'b0;
      q_scalar_sel <= 1'b0;
      q_scalar     <= '0;
      q_vd         <= '0;
      q_vs2        <= '0;
      q_vs1        <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_valid) begin
          q_sew        <= cmd_sew;
          q_arith      <= cmd_arith;
          q_scalar_sel <= cmd_scalar_sel;
          q_scalar     <= cmd_scalar;
          q_vd         <= cmd_vd;
          q_vs2        <= cmd_vs2;
          q_vs1        <= cmd_vs1;
          vl_q         <= cmd_vl;
          mask_q       <= cmd_unmasked ? '1 : v0_bits;
          if (cmd_vstart < cmd_vl) begin
            idx <= cmd_vstart;
            st  <= ST_RUN;
          end else begin
            idx   <= '0;
            dirty <= 1'b1;
            st    <= ST_FIN;
          end
        end
        ST_RUN: begin
          if ((idx + IW'(1)) == vl_q) begin
            idx   <= '0;
            dirty <= 1'b1;
            st    <= ST_FIN;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  finish_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idx == '0) && dirty);
  // R11
  empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_vstart >= cmd_vl)) |=> done);
  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (idx < vl_q));
endmodule

// File: rtl/nsu_top.sv
module nsu_top #(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int XLEN = 32,
  localparam int VLENB = VLEN / 8,
  localparam int AW = $clog2(NREG * VLENB),
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_sew,
  input  logic            cmd_arith,
  input  logic            cmd_scalar_sel,
  input  logic [XLEN-1:0] cmd_scalar,
  input  logic            cmd_unmasked,
  input  logic [IW-1:0]   cmd_vstart,
  input  logic [IW-1:0]   cmd_vl,
  input  logic [RW-1:0]   cmd_vd,
  input  logic [RW-1:0]   cmd_vs2,
  input  logic [RW-1:0]   cmd_vs1,
  input  logic            host_we,
  input  logic [RW-1:0]   host_reg,
  input  logic [VLEN-1:0] host_wdata,
  output logic [VLEN-1:0] host_rdata,
  output logic            busy,
  output logic            done,
  output logic [IW-1:0]   vstart_o,
  output logic            dirty
);
  logic [1:0]      q_sew;
  logic            q_arith, q_scalar_sel, elem_we;
  logic [XLEN-1:0] q_scalar, shamt;
  logic [RW-1:0]   q_vd, q_vs2, q_vs1;
  logic [IW-1:0]   idx;
  logic [VLEN-1:0] v0_bits;
  logic [AW-1:0]   wide_addr, amt_addr, wr_addr;
  logic [63:0]     wide_data;
  logic [7:0]      amt_byte;
  logic [31:0]     result;
  logic [3:0]      nb;

  assign vstart_o = idx;

  nsu_seq #(.NREG(NREG), .VLEN(VLEN), .XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sew(cmd_sew), .cmd_arith(cmd_arith), .cmd_scalar_sel(cmd_scalar_sel),
    .cmd_scalar(cmd_scalar), .cmd_unmasked(cmd_unmasked), .cmd_vstart(cmd_vstart),
    .cmd_vl(cmd_vl), .cmd_vd(cmd_vd), .cmd_vs2(cmd_vs2), .cmd_vs1(cmd_vs1),
    .v0_bits(v0_bits), .q_sew(q_sew), .q_arith(q_arith), .q_scalar_sel(q_scalar_sel),
    .q_scalar(q_scalar), .q_vd(q_vd), .q_vs2(q_vs2), .q_vs1(q_vs1), .idx(idx),
    .elem_we(elem_we), .busy(busy), .done(done), .dirty(dirty)
  );

  // element byte addresses; group registers are contiguous in the byte space
  always_comb begin
    nb        = nsu_pkg::sew_nbytes(q_sew);
    wide_addr = AW'(int'(q_vs2) * VLENB + int'(idx) * 2 * int'(nb));
    amt_addr  = AW'(int'(q_vs1) * VLENB + int'(idx) * int'(nb));
    wr_addr   = AW'(int'(q_vd) * VLENB + int'(idx) * int'(nb));
    // only the low byte of a vector amount can survive the 2*SEW-1 mask
    shamt     = q_scalar_sel ? q_scalar : XLEN'(amt_byte);
  end

  nsu_regfile #(.NREG(NREG), .VLEN(VLEN)) u_rf (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_block(busy),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .v0_bits(v0_bits), .wide_addr(wide_addr), .wide_data(wide_data),
    .amt_addr(amt_addr), .amt_byte(amt_byte), .wr_en(elem_we),
    .wr_addr(wr_addr), .wr_nb(nb), .wr_data(result)
  );

  nsu_alu #(.XLEN(XLEN)) u_alu (
    .sew(q_sew), .arith(q_arith), .wide(wide_data), .shamt_raw(shamt),
    .result(result)
  );

  // R12
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !elem_we);
  // R12
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready);
endmodule

// File: tb/nsu_top_test.sv
module nsu_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int VLEN = 64;
  localparam int XLEN = 32;
  localparam int VLENB = VLEN / 8;
  localparam int NBYTE = NREG * VLENB;
  localparam int RW = $clog2(NREG);
  localparam int IW = $clog2(VLEN) + 1;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [1:0]      sew;
    logic            arith;
    logic            ssel;
    logic [XLEN-1:0] scal;
    logic            unm;
    logic [IW-1:0]   vst;
    logic [IW-1:0]   vl;
    logic [RW-1:0]   vd;
    logic [RW-1:0]   vs2;
    logic [RW-1:0]   vs1;
  } vec_t;

  // sew arith ssel scalar unm vst vl vd vs2 vs1
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 32'd0,  1'b1, 7'd0, 7'd8,  3'd1, 3'd2, 3'd4}, // R3 R6 R7
    '{2'd0, 1'b1, 1'b0, 32'd0,  1'b1, 7'd0, 7'd8,  3'd1, 3'd2, 3'd4}, // R5
    '{2'd1, 1'b0, 1'b1, 32'd35, 1'b1, 7'd0, 7'd4,  3'd1, 3'd2, 3'd0}, // R4
    '{2'd1, 1'b1, 1'b1, 32'h1f, 1'b1, 7'd0, 7'd6,  3'd1, 3'd4, 3'd0}, // R4 R5
    '{2'd2, 1'b0, 1'b0, 32'd0,  1'b1, 7'd0, 7'd4,  3'd2, 3'd4, 3'd0}, // R2 R3
    '{2'd2, 1'b1, 1'b1, 32'd63, 1'b1, 7'd0, 7'd3,  3'd1, 3'd4, 3'd0}, // R5 full shift
    '{2'd0, 1'b1, 1'b0, 32'd0,  1'b0, 7'd0, 7'd16, 3'd2, 3'd4, 3'd0}, // R8
    '{2'd1, 1'b0, 1'b0, 32'd0,  1'b1, 7'd2, 7'd5,  3'd1, 3'd4, 3'd6}, // R9
    '{2'd0, 1'b0, 1'b1, 32'd1,  1'b1, 7'd5, 7'd5,  3'd1, 3'd2, 3'd0}, // R11
    '{2'd1, 1'b1, 1'b1, 32'd1,  1'b1, 7'd6, 7'd3,  3'd1, 3'd2, 3'd0}, // R11
    '{2'd0, 1'b0, 1'b1, 32'd2,  1'b0, 7'd0, 7'd8,  3'd0, 3'd2, 3'd0}, // R8 mask snapshot
    '{2'd0, 1'b1, 1'b1, 32'd16, 1'b1, 7'd1, 7'd7,  3'd3, 3'd4, 3'd0}  // R4 R9
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [1:0]      cmd_sew = '0;
  logic            cmd_arith = 1'b0;
  logic            cmd_scalar_sel = 1'b0;
  logic [XLEN-1:0] cmd_scalar = '0;
  logic            cmd_unmasked = 1'b0;
  logic [IW-1:0]   cmd_vstart = '0;
  logic [IW-1:0]   cmd_vl = '0;
  logic [RW-1:0]   cmd_vd = '0, cmd_vs2 = '0, cmd_vs1 = '0;
  logic            host_we = 1'b0;
  logic [RW-1:0]   host_reg = '0;
  logic [VLEN-1:0] host_wdata = '0;
  logic [VLEN-1:0] host_rdata;
  logic            busy, done, dirty;
  logic [IW-1:0]   vstart_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] mdl [NBYTE];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nsu_top #(.NREG(NREG), .VLEN(VLEN), .XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sew(cmd_sew), .cmd_arith(cmd_arith), .cmd_scalar_sel(cmd_scalar_sel),
    .cmd_scalar(cmd_scalar), .cmd_unmasked(cmd_unmasked), .cmd_vstart(cmd_vstart),
    .cmd_vl(cmd_vl), .cmd_vd(cmd_vd), .cmd_vs2(cmd_vs2), .cmd_vs1(cmd_vs1),
    .host_we(host_we), .host_reg(host_reg), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .done(done), .vstart_o(vstart_o),
    .dirty(dirty)
  );

  task automatic check(input string req, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input int r, input logic [VLEN-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_reg = RW'(r); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic load_all(input int seed);
    for (int r = 0; r < NREG; r++) begin
      logic [VLEN-1:0] d;
      for (int b = 0; b < VLENB; b++) begin
        mdl[r*VLENB + b] = 8'((r*VLENB + b) * 73 + seed * 29 + 145);
        d[8*b +: 8] = mdl[r*VLENB + b];
      end
      host_write(r, d);
    end
  endtask

  task automatic compare_regs(input string req);
    logic [VLEN-1:0] exp;
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      host_reg = RW'(r);
      #1;
      for (int b = 0; b < VLENB; b++) exp[8*b +: 8] = mdl[r*VLENB + b];
      check(req, host_rdata, exp);
    end
  endtask

  task automatic model_exec(input vec_t v);
    logic [VLEN-1:0] msk;
    logic [63:0] w, s, res;
    int nb, wb, amt;
    for (int b = 0; b < VLENB; b++) msk[8*b +: 8] = mdl[b];
    if (v.unm) msk = '1;
    nb = 1 << v.sew;
    wb = 16 * nb;
    for (int i = int'(v.vst); i < int'(v.vl); i++) begin
      if (msk[i]) begin
        w = '0;
        for (int k = 0; k < 2*nb; k++)
          w[8*k +: 8] = mdl[(int'(v.vs2)*VLENB + i*2*nb + k) % NBYTE];
        s = '0;
        if (v.ssel) s = 64'(v.scal);
        else for (int k = 0; k < nb; k++)
          s[8*k +: 8] = mdl[(int'(v.vs1)*VLENB + i*nb + k) % NBYTE];
        amt = int'(s % 64'(wb));
        if (v.arith && w[wb-1] && wb < 64) w = w | (~64'd0 << wb);
        res = v.arith ? 64'($signed(w) >>> amt) : (w >> amt);
        for (int k = 0; k < nb; k++)
          mdl[(int'(v.vd)*VLENB + i*nb + k) % NBYTE] = res[8*k +: 8];
      end
    end
  endtask

  // drives one command; returns edges from accept (counted as 1) to done
  task automatic run_cmd(input vec_t v, input bit inject, output int edges);
    @(negedge clk);
    cmd_sew = v.sew; cmd_arith = v.arith; cmd_scalar_sel = v.ssel;
    cmd_scalar = v.scal; cmd_unmasked = v.unm; cmd_vstart = v.vst;
    cmd_vl = v.vl; cmd_vd = v.vd; cmd_vs2 = v.vs2; cmd_vs1 = v.vs1;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    edges = 1;
    if (inject) begin
      // R12: command port and host writes refused while busy
      check("R12 ready low while busy", VLEN'(cmd_ready), '0);
      host_we = 1'b1; host_reg = 3'd7; host_wdata = 64'hdead_beef_0bad_f00d;
      cmd_valid = 1'b1; cmd_vstart = 7'd0; cmd_vl = 7'd1; cmd_vd = 3'd7;
    end
    while (!done && edges < 200) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      host_we = 1'b0;
      cmd_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int edges, expe;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    check("R1 cmd_ready", VLEN'(cmd_ready), 64'd1);
    check("R1 busy/done/dirty", VLEN'({busy, done, dirty}), '0);
    check("R1 vstart_o", VLEN'(vstart_o), '0);
    for (int b = 0; b < NBYTE; b++) mdl[b] = '0;
    compare_regs("R1 registers zero");

    for (int t = 0; t < NVEC; t++) begin
      load_all(t);
      model_exec(VEC[t]);
      run_cmd(VEC[t], 1'b0, edges);
      expe = (VEC[t].vst < VEC[t].vl) ? int'(VEC[t].vl - VEC[t].vst) + 1 : 1;
      // R10 / R11 latency
      check("R10 R11 done latency", VLEN'(edges), VLEN'(expe));
      check("R10 vstart_o cleared and dirty", VLEN'({vstart_o, dirty}), VLEN'({7'd0, 1'b1}));
      @(negedge clk);
      check("R10 done one cycle", VLEN'({done, cmd_ready}), VLEN'(2'b01));
      // R2 R3 R4 R5 R6 R7 R8 R9 R11 data
      compare_regs("R2-data");
    end

    // R12: host write and new command offered during a run have no effect
    load_all(40);
    model_exec(VEC[0]);
    run_cmd(VEC[0], 1'b1, edges);
    check("R12 latency unchanged", VLEN'(edges), VLEN'(9));
    repeat (3) @(negedge clk);
    check("R12 no second command", VLEN'({busy, done}), '0);
    compare_regs("R12 host write ignored");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule